// File: doc/BRIEF.md
# Legacy Replacement Interrupt Router

This block sits behind a bank of event-timer channels and decides which interrupt output line each channel's request reaches. In normal operation every channel names its own line through a 5-bit route field. Two external interrupt sources pass straight through to their usual lines: the legacy system timer goes to line 0 and the real-time clock goes to line 8.

When the legacy replacement bit is set, the block takes those two lines over. Channel 0 is tied to line 0 and channel 1 is tied to line 8, whatever their route fields say. The external sources are muted, and an enable output tells the legacy timer to stop. The RTC input is sampled on every clock, so that its most recent level can be put back on line 8 when legacy mode ends.

Lines 16 and above follow an inverted convention, in which a request pulls the line low. All outputs are registered, so each output reflects the inputs sampled at the previous rising clock edge.

Top module: `legacy_irq_router`

## Requirements
- R1: While `legacyMode` is 1, a request on channel 0 asserts line 0 and a request on channel 1 asserts line 8, and the route fields of those two channels have no effect.
- R2: Channel c's route field is `chanRoute[c*5 +: 5]`. While `legacyMode` is 0, every requesting channel asserts the line named by its route field. Channels 2 and up do this in both modes. Outputs follow the inputs one rising edge later.
- R3: While `legacyMode` is 0 (and was 0 at the previous edge), `extTimerIrq` drives line 0 and `extRtcIrq` drives line 8. While `legacyMode` is 1, neither external source has any effect on any line.
- R4: `extRtcIrq` is captured at every rising edge, including while `legacyMode` is 1.
- R5: On entering legacy mode, lines 0 and 8 stop carrying the external sources, and `legacyTimerEn` reads 0 after the first edge that samples `legacyMode` = 1.
- R6: At the first edge that samples `legacyMode` = 0 after legacy mode, three things happen. `extTimerIrq` does not reach line 0 for that cycle. Line 8 takes the RTC level captured at the edge before. `legacyTimerEn` returns to 1.
- R7: Lines with index 16 or higher are active-low: asserted means 0 and released means 1. Lines below 16 are active-high.
- R8: While `rst_n` is 0, `legacyTimerEn` is 1, lines 15..0 read 0, lines 31..16 read 1, and the captured RTC level is 0.
- R9: When several channels select the same line, their requests are ORed before the polarity of R7 is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| legacyMode | input | 1 | Legacy replacement mode select |
| chanReq | input | 4 | Per-channel interrupt request level |
| chanRoute | input | 20 | Packed 5-bit route fields, channel c at bits c*5 +: 5 |
| extTimerIrq | input | 1 | External legacy system-timer interrupt |
| extRtcIrq | input | 1 | External real-time-clock interrupt |
| irqLines | output | 32 | Interrupt output lines, 16 and above active-low |
| legacyTimerEn | output | 1 | Enable for the legacy system timer |

## Verification
Two functions can meet in a single cycle: the restore of the captured RTC level when legacy mode ends, and a fresh change on the live RTC input. The bench provokes this by raising `extRtcIrq` while legacy mode is active, then dropping both `legacyMode` and `extRtcIrq` at the same edge. In that cycle line 8 must show the old captured 1, and line 0 must stay released even though the timer input is high. One cycle later both lines must follow the live inputs.

// File: rtl/lrr_pkg.sv
package lrr_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic legacyOn;      // forced routing of channels 0 and 1
    logic extTimerGate;  // external timer may reach its line
    logic extRtcGate;    // live RTC input may reach its line
    logic useRtcLatch;   // put the captured RTC level on its line
  } lrrCtrl_t;

  // Build the inversion mask: bit i is set when line i is active-low.
  function automatic logic [63:0] buildInvMask(input int numLines, input int invBase);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < numLines; i++) begin
      if (i >= invBase) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/lrr_ctrl.sv
module lrr_ctrl
  import lrr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     legacyMode,
  output lrrCtrl_t ctrl,
  output logic     legacyTimerEn
);

  logic legacyPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      legacyPrev    <= 1'b0;
      legacyTimerEn <= 1'b1;
    end else begin
      legacyPrev    <= legacyMode;
      legacyTimerEn <= ~legacyMode;
    end
  end

  logic leaveNow;
  assign leaveNow = legacyPrev & ~legacyMode;

  always_comb begin
    ctrl.legacyOn     = legacyMode;
    ctrl.extTimerGate = ~legacyMode & ~legacyPrev;
    ctrl.extRtcGate   = ~legacyMode & ~legacyPrev;
    ctrl.useRtcLatch  = leaveNow;
  end

endmodule

// File: rtl/lrr_datapath.sv
module lrr_datapath
  import lrr_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int ROUTE_W    = 5,
  parameter int TIMER_LINE = 0,
  parameter int RTC_LINE   = 8,
  parameter int INV_BASE   = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  lrrCtrl_t                      ctrl,
  input  logic [NUM_CH-1:0]             chanReq,
  input  logic [NUM_CH*ROUTE_W-1:0]     chanRoute,
  input  logic                          extTimerIrq,
  input  logic                          extRtcIrq,
  output logic [(1<<ROUTE_W)-1:0]       irqLines
);

  localparam int NUM_LINES = 1 << ROUTE_W;
  localparam logic [63:0] INV_FULL = buildInvMask(NUM_LINES, INV_BASE);
  localparam logic [NUM_LINES-1:0] INV_MASK = INV_FULL[NUM_LINES-1:0];
  localparam logic [ROUTE_W-1:0] TIMER_R = ROUTE_W'(TIMER_LINE);
  localparam logic [ROUTE_W-1:0] RTC_R   = ROUTE_W'(RTC_LINE);

  logic rtcLatch;
  logic [NUM_CH-1:0][NUM_LINES-1:0] chanHit;
  logic [NUM_LINES-1:0] activeNext;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [ROUTE_W-1:0] field;
    logic [ROUTE_W-1:0] effRoute;
    assign field = chanRoute[ch*ROUTE_W +: ROUTE_W];
    if (ch == 0) begin : g_forceTimer
      assign effRoute = ctrl.legacyOn ? TIMER_R : field;
    end else if (ch == 1) begin : g_forceRtc
      assign effRoute = ctrl.legacyOn ? RTC_R : field;
    end else begin : g_plain
      assign effRoute = field;
    end
    assign chanHit[ch] = chanReq[ch] ? (NUM_LINES'(1) << effRoute) : '0;
  end

  always_comb begin
    activeNext = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      activeNext = activeNext | chanHit[ch];
    end
    activeNext[TIMER_LINE] = activeNext[TIMER_LINE] | (ctrl.extTimerGate & extTimerIrq);
    activeNext[RTC_LINE]   = activeNext[RTC_LINE]
                           | (ctrl.extRtcGate & extRtcIrq)
                           | (ctrl.useRtcLatch & rtcLatch);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtcLatch <= 1'b0;
      irqLines <= INV_MASK;
    end else begin
      rtcLatch <= extRtcIrq;
      irqLines <= activeNext ^ INV_MASK;
    end
  end

endmodule

// File: rtl/legacy_irq_router.sv
module legacy_irq_router
  import lrr_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int ROUTE_W    = 5,
  parameter int TIMER_LINE = 0,
  parameter int RTC_LINE   = 8,
  parameter int INV_BASE   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        legacyMode,
  input  logic [NUM_CH-1:0]           chanReq,
  input  logic [NUM_CH*ROUTE_W-1:0]   chanRoute,
  input  logic                        extTimerIrq,
  input  logic                        extRtcIrq,
  output logic [(1<<ROUTE_W)-1:0]     irqLines,
  output logic                        legacyTimerEn
);

  lrrCtrl_t ctrl;

  lrr_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .legacyMode   (legacyMode),
    .ctrl         (ctrl),
    .legacyTimerEn(legacyTimerEn)
  );

  lrr_datapath #(
    .NUM_CH    (NUM_CH),
    .ROUTE_W   (ROUTE_W),
    .TIMER_LINE(TIMER_LINE),
    .RTC_LINE  (RTC_LINE),
    .INV_BASE  (INV_BASE)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl),
    .chanReq    (chanReq),
    .chanRoute  (chanRoute),
    .extTimerIrq(extTimerIrq),
    .extRtcIrq  (extRtcIrq),
    .irqLines   (irqLines)
  );

endmodule

// File: rtl/legacy_irq_router_chk.sv
module legacy_irq_router_chk #(
  parameter int NUM_CH   = 4,
  parameter int UPPER_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               legacyMode,
  input logic [NUM_CH-1:0]  chanReq,
  input logic               extTimerIrq,
  input logic               extRtcIrq,
  input logic               timerLine,
  input logic               rtcLine,
  input logic [UPPER_W-1:0] upperLines,
  input logic               legacyTimerEn
);

  logic seenLegacy;
  logic seenRtc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seenLegacy <= 1'b0;
      seenRtc    <= 1'b0;
    end else begin
      seenLegacy <= legacyMode;
      seenRtc    <= extRtcIrq;
    end
  end

  assert_timer_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    legacyMode |=> !legacyTimerEn);

  assert_timer_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !legacyMode |=> legacyTimerEn);

  assert_timer_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!legacyMode && !seenLegacy && extTimerIrq) |=> timerLine);

  assert_leave_line0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seenLegacy && !legacyMode && chanReq == '0) |=> !timerLine);

  assert_leave_rtc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seenLegacy && !legacyMode && chanReq == '0) |=> (rtcLine == $past(seenRtc)));

  assert_forced_ch0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (legacyMode && chanReq[0]) |=> timerLine);

  assert_upper_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chanReq == '0) |=> (&upperLines));

endmodule

bind legacy_irq_router legacy_irq_router_chk #(
  .NUM_CH (NUM_CH),
  .UPPER_W((1<<ROUTE_W) - INV_BASE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .legacyMode   (legacyMode),
  .chanReq      (chanReq),
  .extTimerIrq  (extTimerIrq),
  .extRtcIrq    (extRtcIrq),
  .timerLine    (irqLines[TIMER_LINE]),
  .rtcLine      (irqLines[RTC_LINE]),
  .upperLines   (irqLines[(1<<ROUTE_W)-1:INV_BASE]),
  .legacyTimerEn(legacyTimerEn)
);

// File: tb/legacy_irq_router_tb.sv
module legacy_irq_router_tb;

  localparam logic [31:0] INV = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        legacyMode = 1'b0;
  logic [3:0]  chanReq = '0;
  logic [19:0] chanRoute = '0;
  logic        extTimerIrq = 1'b0;
  logic        extRtcIrq = 1'b0;
  logic [31:0] irqLines;
  logic        legacyTimerEn;

  int testsRun = 0;
  int testsFail = 0;

  always #5 clk = ~clk;

  legacy_irq_router u_dut (
    .clk(clk), .rst_n(rst_n), .legacyMode(legacyMode), .chanReq(chanReq),
    .chanRoute(chanRoute), .extTimerIrq(extTimerIrq), .extRtcIrq(extRtcIrq),
    .irqLines(irqLines), .legacyTimerEn(legacyTimerEn)
  );

  typedef struct packed {
    logic        leg;
    logic [3:0]  req;
    logic [19:0] routes;  // {r3, r2, r1, r0}
    logic        extT;
    logic        extR;
    logic [31:0] act;     // expected active lines before polarity
    logic [3:0]  reqId;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'b0000, {5'd0, 5'd0, 5'd0, 5'd0},   1'b0, 1'b0, 32'h0000_0000, 4'd2}, // R2 idle
    '{1'b0, 4'b0001, {5'd0, 5'd0, 5'd0, 5'd3},   1'b0, 1'b0, 32'h0000_0008, 4'd2}, // R2
    '{1'b0, 4'b0010, {5'd0, 5'd0, 5'd20, 5'd0},  1'b0, 1'b0, 32'h0010_0000, 4'd7}, // R7
    '{1'b0, 4'b1100, {5'd5, 5'd5, 5'd0, 5'd0},   1'b0, 1'b0, 32'h0000_0020, 4'd9}, // R9
    '{1'b0, 4'b0000, {5'd0, 5'd0, 5'd0, 5'd0},   1'b1, 1'b0, 32'h0000_0001, 4'd3}, // R3
    '{1'b0, 4'b0000, {5'd0, 5'd0, 5'd0, 5'd0},   1'b0, 1'b1, 32'h0000_0100, 4'd3}, // R3
    '{1'b0, 4'b1001, {5'd16, 5'd0, 5'd0, 5'd31}, 1'b0, 1'b0, 32'h8001_0000, 4'd7}, // R7
    '{1'b1, 4'b0001, {5'd0, 5'd0, 5'd0, 5'd3},   1'b0, 1'b0, 32'h0000_0001, 4'd1}, // R1, R5
    '{1'b1, 4'b0010, {5'd0, 5'd0, 5'd20, 5'd0},  1'b0, 1'b0, 32'h0000_0100, 4'd1}, // R1
    '{1'b1, 4'b0000, {5'd0, 5'd0, 5'd0, 5'd0},   1'b1, 1'b1, 32'h0000_0000, 4'd5}, // R5, R3 muted
    '{1'b1, 4'b0100, {5'd0, 5'd12, 5'd0, 5'd0},  1'b0, 1'b0, 32'h0000_1000, 4'd2}  // R2
  };

  task automatic check(input string tag, input logic [31:0] gotL, input logic [31:0] expL,
                       input logic gotE, input logic expE);
    testsRun++;
    if (gotL !== expL || gotE !== expE) begin
      testsFail++;
      $display("FAIL %s lines=%h exp=%h en=%b exp=%b", tag, gotL, expL, gotE, expE);
    end
  endtask

  initial begin : watchdog
    #1000000;
    testsFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset", irqLines, INV, legacyTimerEn, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", irqLines, INV, legacyTimerEn, 1'b1);

    for (int i = 0; i < NV; i++) begin
      legacyMode  = VECS[i].leg;
      chanReq     = VECS[i].req;
      chanRoute   = VECS[i].routes;
      extTimerIrq = VECS[i].extT;
      extRtcIrq   = VECS[i].extR;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].reqId, i), irqLines,
            VECS[i].act ^ INV, legacyTimerEn, ~VECS[i].leg);
    end

    // R4 / R6: RTC raised during legacy, then legacy and RTC both drop together.
    legacyMode = 1'b1; chanReq = '0; chanRoute = '0; extTimerIrq = 1'b1; extRtcIrq = 1'b1;
    @(negedge clk);
    check("R4 rtc captured while muted", irqLines, INV, legacyTimerEn, 1'b0);
    legacyMode = 1'b0; extRtcIrq = 1'b0;
    @(negedge clk);
    check("R6 leave cycle restores latched rtc, line0 released", irqLines,
          32'h0000_0100 ^ INV, legacyTimerEn, 1'b1);
    @(negedge clk);
    check("R3 passthrough after leave", irqLines, 32'h0000_0001 ^ INV, legacyTimerEn, 1'b1);

    // R6: leave with RTC low before, timer high: both lines released.
    legacyMode = 1'b1; extRtcIrq = 1'b0;
    @(negedge clk);
    legacyMode = 1'b0; extRtcIrq = 1'b1;
    @(negedge clk);
    check("R6 leave cycle with rtc latch 0", irqLines, INV, legacyTimerEn, 1'b1);
    @(negedge clk);
    check("R3 both passthrough", irqLines, 32'h0000_0101 ^ INV, legacyTimerEn, 1'b1);

    // R8: reset mid-run returns to released state.
    chanReq = 4'b0001; chanRoute = {15'd0, 5'd17};
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 async reset", irqLines, INV, legacyTimerEn, 1'b1);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule